// File: doc/BRIEF.md
# Dual-Mode Redundant Memory Datapath

This block sits between a host port that behaves like a plain SRAM (address, data, write and read strobes) and a 48-bit external memory bus. The external bus is built from six 8-bit lanes, which are grouped into three 16-bit banks. Bank 0 is bus bits 15:0, bank 1 is bits 31:16 and bank 2 is bits 47:32. A static mode input chooses how the 48 bits are used.

In triplicated mode, each 16-bit host word is stored in all three banks. A read returns the bitwise two-of-three majority of the banks. In protected mode, banks 0 and 1 carry a 32-bit host word and bank 2 carries a Hamming single-error-correct, double-error-detect code. Protected mode therefore gives twice the usable capacity of the same array. A 48-bit XOR mask on the read path lets a bench or a self-test routine plant upsets in returned data, so that both mitigation schemes can be shown to work.

Command sequencing, refresh and clocking of the memory are outside this block. A simple array behind the bus stands in for the memory.

Top module: `dual_mode_mem_path`

## Requirements
- R1: While reset is asserted and on the first cycles after it, hostRdValid and all three error flags are 0.
- R2: memAddr equals hostAddr, memWe equals hostWe, and memRe equals hostRe with hostWe low, all in the same cycle. In triplicated mode (modeEdac=0) a write drives hostWrData[15:0] onto each of the three banks, and hostWrData[31:16] has no effect.
- R3: In triplicated mode a read returns, in hostRdData[15:0], the bitwise majority of the three banks, and returns zero in hostRdData[31:16].
- R4: In triplicated mode errVoteMismatch is 1 on a read result whenever the three banks are not all equal. It is never 1 in protected mode.
- R5: In protected mode (modeEdac=1) a write drives the data word on bus bits 31:0 and a code on bus bits 38:32. The code is built as follows. Hamming positions 1..38 hold check bits at positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the remaining positions in ascending order. Check bit k (on bus bit 32+k) is the XOR of the data bits whose position has bit k set. Bus bit 38 is the XOR of all 32 data bits and the six check bits. Bus bits 47:39 are driven 0.
- R6: In protected mode a read with no upset returns the stored word with no flag raised. Bus bits 47:39 of the read data have no effect.
- R7: In protected mode, flipping any single one of bus bits 38:0 returns the original word with errCorrected set.
- R8: In protected mode, flipping two of bus bits 38:0 sets errUncorrectable and returns read bits 31:0 unmodified. At most one of the three error flags is ever set.
- R9: The read data seen by voting and decoding is memRdData XOR injectMask, bit for bit.
- R10: Read data and flags are registered. They appear with hostRdValid=1 exactly one cycle after the cycle in which memRdValid is 1, and hostRdValid is 0 otherwise. The flags are 0 whenever hostRdValid is 0.
- R11: modeEdac stays unchanged while a read is outstanding. A mode change made between accesses applies to the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeEdac | input | 1 | 0 = triplicated, 1 = protected (SEC-DED) |
| hostAddr | input | ADDR_W | Host word address |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Registered read data |
| hostRdValid | output | 1 | Read result present this cycle |
| errVoteMismatch | output | 1 | A bank disagreed with the vote |
| errCorrected | output | 1 | Single-bit error corrected |
| errUncorrectable | output | 1 | Double error detected, raw data returned |
| memAddr | output | ADDR_W | Memory address |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read request |
| memWrData | output | 48 | Encoded write word |
| memRdData | input | 48 | Raw word from memory |
| memRdValid | input | 1 | memRdData is valid this cycle |
| injectMask | input | 48 | Upset injection XOR mask on read data |

## Verification
The write side is purely combinational. The bench therefore samples memAddr, memWe, memRe and memWrData a fraction of a cycle after it drives the host strobes, in the same cycle. Read results carry one register. The bench presents memRdData with memRdValid for one cycle and compares data and flags at the next falling edge, after the capturing rising edge. A per-clock monitor samples memRdValid at each rising edge and then compares hostRdValid and the flags shortly after that edge. This pins the latency at exactly one cycle, with no early or stray pulses.

// File: rtl/dmmp_pkg.sv
package dmmp_pkg;
  localparam int LANE_W   = 8;
  localparam int LANE_CNT = 6;
  localparam int BANK_CNT = 3;
  localparam int BUS_W    = LANE_W * LANE_CNT;
  localparam int BANK_W   = BUS_W / BANK_CNT;
  localparam int WORD_W   = 2 * BANK_W;
  localparam int CHK_W    = 6;
  localparam int TOP_POS  = WORD_W + CHK_W;
  localparam int CODE_W   = TOP_POS + 1;

  typedef struct packed {
    logic edac;
    logic wrEn;
    logic capture;
  } dmmpStrobe_t;

  // Data bits covered by check bit k.
  function automatic logic [WORD_W-1:0] chkMask(input int k);
    logic [WORD_W-1:0] m;
    int d;
    m = '0;
    d = 0;
    for (int p = 1; p <= TOP_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (((p >> k) & 1) == 1) m[d] = 1'b1;
        d++;
      end
    end
    return m;
  endfunction

  // Hamming position that holds data bit idx.
  function automatic int dataPos(input int idx);
    int d;
    int res;
    d = 0;
    res = 0;
    for (int p = 1; p <= TOP_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d == idx) res = p;
        d++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/dmmp_ctrl.sv
module dmmp_ctrl
  import dmmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeEdac,
  input  logic        hostWe,
  input  logic        hostRe,
  input  logic        memRdValid,
  output dmmpStrobe_t strobe,
  output logic        memWe,
  output logic        memRe
);
  logic pendingRd;

  assign memWe          = hostWe;
  assign memRe          = hostRe & ~hostWe;
  assign strobe.edac    = modeEdac;
  assign strobe.wrEn    = hostWe;
  assign strobe.capture = memRdValid;

  always_ff @(posedge clk) begin
    if (!rstN)           pendingRd <= 1'b0;
    else if (memRe)      pendingRd <= 1'b1;
    else if (memRdValid) pendingRd <= 1'b0;
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pendingRd |-> $stable(modeEdac)); // R11
endmodule

// File: rtl/dmmp_datapath.sv
module dmmp_datapath
  import dmmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dmmpStrobe_t       strobe,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [BUS_W-1:0]  memWrData,
  input  logic [BUS_W-1:0]  memRdData,
  input  logic [BUS_W-1:0]  injectMask,
  output logic [WORD_W-1:0] hostRdData,
  output logic              hostRdValid,
  output logic              errVoteMismatch,
  output logic              errCorrected,
  output logic              errUncorrectable
);
  localparam int PAD_W = BANK_W - CHK_W - 1;

  logic [CHK_W-1:0]  wrChk, rdSyn;
  logic              wrParity, rdParity, posOk, isSingle, isDouble;
  logic [BUS_W-1:0]  rdCode, encEdac, encTriple;
  logic [WORD_W-1:0] rdWord, fixWord;
  logic [BANK_W-1:0] bank [BANK_CNT];
  logic [BANK_W-1:0] vote;
  logic              voteMis;

  assign rdCode = memRdData ^ injectMask;
  assign rdWord = rdCode[WORD_W-1:0];

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    assign bank[b] = rdCode[b*BANK_W +: BANK_W];
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [WORD_W-1:0] COVER = chkMask(k);
    assign wrChk[k] = ^(hostWrData & COVER);
    assign rdSyn[k] = (^(rdWord & COVER)) ^ rdCode[WORD_W + k];
  end

  // write encoding
  assign wrParity  = (^hostWrData) ^ (^wrChk);
  assign encEdac   = {{PAD_W{1'b0}}, wrParity, wrChk, hostWrData};
  assign encTriple = {BANK_CNT{hostWrData[BANK_W-1:0]}};
  assign memWrData = !strobe.wrEn ? '0 : (strobe.edac ? encEdac : encTriple);

  // majority vote
  assign vote    = (bank[0] & bank[1]) | (bank[0] & bank[2]) | (bank[1] & bank[2]);
  assign voteMis = (bank[0] != vote) | (bank[1] != vote) | (bank[2] != vote);

  // SEC-DED decode
  assign rdParity = (^rdWord) ^ (^rdCode[WORD_W +: CHK_W]) ^ rdCode[TOP_POS];
  assign posOk    = rdSyn <= CHK_W'(TOP_POS);
  assign isSingle = rdParity & posOk;
  assign isDouble = (~rdParity & (rdSyn != '0)) | (rdParity & ~posOk);

  for (genvar i = 0; i < WORD_W; i++) begin : g_fix
    localparam int POS = dataPos(i);
    assign fixWord[i] = rdWord[i] ^ (isSingle && (rdSyn == CHK_W'(POS)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData       <= '0;
      hostRdValid      <= 1'b0;
      errVoteMismatch  <= 1'b0;
      errCorrected     <= 1'b0;
      errUncorrectable <= 1'b0;
    end else begin
      hostRdValid      <= strobe.capture;
      errVoteMismatch  <= strobe.capture & ~strobe.edac & voteMis;
      errCorrected     <= strobe.capture & strobe.edac & isSingle;
      errUncorrectable <= strobe.capture & strobe.edac & isDouble;
      if (strobe.capture)
        hostRdData <= strobe.edac ? fixWord : {{BANK_W{1'b0}}, vote};
    end
  end

  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errVoteMismatch, errCorrected, errUncorrectable})); // R8
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (errVoteMismatch || errCorrected || errUncorrectable) |-> hostRdValid); // R10
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> hostRdValid); // R10
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !hostRdValid); // R10
  AST_TRIPLE_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.edac) |->
      (memWrData[0 +: BANK_W] == memWrData[BANK_W +: BANK_W]) &&
      (memWrData[BANK_W +: BANK_W] == memWrData[2*BANK_W +: BANK_W])); // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.edac) |-> (memWrData[BUS_W-1:CODE_W] == '0)); // R5
  AST_TRIPLE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.edac) |=> (hostRdData[WORD_W-1:BANK_W] == '0)); // R3
endmodule

// File: rtl/dual_mode_mem_path.sv
module dual_mode_mem_path
  import dmmp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEdac,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              hostRdValid,
  output logic              errVoteMismatch,
  output logic              errCorrected,
  output logic              errUncorrectable,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [47:0]       memWrData,
  input  logic [47:0]       memRdData,
  input  logic              memRdValid,
  input  logic [47:0]       injectMask
);
  dmmpStrobe_t strobe;

  assign memAddr = hostAddr;

  dmmp_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeEdac   (modeEdac),
    .hostWe     (hostWe),
    .hostRe     (hostRe),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .memWe      (memWe),
    .memRe      (memRe)
  );

  dmmp_datapath uPath (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .hostWrData       (hostWrData),
    .memWrData        (memWrData),
    .memRdData        (memRdData),
    .injectMask       (injectMask),
    .hostRdData       (hostRdData),
    .hostRdValid      (hostRdValid),
    .errVoteMismatch  (errVoteMismatch),
    .errCorrected     (errCorrected),
    .errUncorrectable (errUncorrectable)
  );
endmodule

// File: tb/dual_mode_mem_path_test.sv
`timescale 1ns/1ps
module dual_mode_mem_path_test;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeEdac = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic          hostWe = 1'b0, hostRe = 1'b0;
  logic [31:0]   hostWrData = '0;
  logic [31:0]   hostRdData;
  logic          hostRdValid, errVoteMismatch, errCorrected, errUncorrectable;
  logic [AW-1:0] memAddr;
  logic          memWe, memRe;
  logic [47:0]   memWrData;
  logic [47:0]   memRdData = '0;
  logic          memRdValid = 1'b0;
  logic [47:0]   injectMask = '0;

  logic [47:0] store [int];
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  dual_mode_mem_path #(.ADDR_W(AW)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // expected protected-mode code word, built from Hamming positions
  function automatic logic [47:0] edacWord(input logic [31:0] d);
    bit code [39];
    logic [5:0] c;
    int di;
    di = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) == 0) code[p] = 1'b0;
      else begin code[p] = d[di]; di++; end
    end
    for (int k = 0; k < 6; k++) begin
      c[k] = 1'b0;
      for (int p = 1; p <= 38; p++) if ((p >> k) & 1) c[k] = c[k] ^ code[p];
    end
    return {9'b0, (^d) ^ (^c), c, d};
  endfunction

  function automatic logic [15:0] majority(input logic [47:0] w);
    logic [15:0] v;
    for (int b = 0; b < 16; b++) begin
      int ones;
      ones = int'(w[b]) + int'(w[16+b]) + int'(w[32+b]);
      v[b] = (ones >= 2);
    end
    return v;
  endfunction

  // per-clock monitor: valid one cycle after memRdValid, flags only with valid (R10)
  always @(posedge clk) begin
    logic sv;
    sv = memRdValid;
    #1;
    if (rstN) begin
      chk(hostRdValid == sv, "R10", "hostRdValid timing", 64'(hostRdValid), 64'(sv));
      if (!hostRdValid)
        chk({errVoteMismatch, errCorrected, errUncorrectable} == 3'b0, "R10",
            "flags without valid", 64'({errVoteMismatch, errCorrected, errUncorrectable}), 64'(0));
    end
  end

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d,
                         input logic [47:0] expWord, input string req);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWe = 1'b1;
    #0.5;
    chk(memWe === 1'b1 && memRe === 1'b0, "R2", "write strobes", 64'({memWe, memRe}), 64'(2'b10));
    chk(memAddr === a, "R2", "write address", 64'(memAddr), 64'(a));
    chk(memWrData === expWord, req, "write word", 64'(memWrData), 64'(expWord));
    store[int'(a)] = memWrData;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [47:0] mask,
                        input logic [31:0] expData, input logic [2:0] expFlags,
                        input string req);
    @(negedge clk);
    hostAddr = a; hostRe = 1'b1; injectMask = mask;
    #0.5;
    chk(memRe === 1'b1 && memAddr === a, "R2", "read request", 64'({memRe, memAddr}), 64'({1'b1, a}));
    @(negedge clk);
    hostRe = 1'b0;
    memRdData = store[int'(a)];
    memRdValid = 1'b1;
    @(negedge clk);
    memRdValid = 1'b0;
    chk(hostRdValid === 1'b1, "R10", "result valid", 64'(hostRdValid), 64'(1));
    chk(hostRdData === expData, req, "read data", 64'(hostRdData), 64'(expData));
    chk({errVoteMismatch, errCorrected, errUncorrectable} === expFlags, req, "flags",
        64'({errVoteMismatch, errCorrected, errUncorrectable}), 64'(expFlags));
    injectMask = '0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [47:0] w, m;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({hostRdValid, errVoteMismatch, errCorrected, errUncorrectable} == 4'b0, "R1",
        "reset outputs", 64'({hostRdValid, errVoteMismatch, errCorrected, errUncorrectable}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk({hostRdValid, errVoteMismatch, errCorrected, errUncorrectable} == 4'b0, "R1",
        "after reset", 64'({hostRdValid, errVoteMismatch, errCorrected, errUncorrectable}), 64'(0));

    // R2 triplicated write, upper half ignored
    doWrite(12'h003, 32'hDEAD_A5C3, {3{16'hA5C3}}, "R2");
    doWrite(12'h004, 32'h0000_0F0F, {3{16'h0F0F}}, "R2");
    // R3 clean vote
    doRead(12'h003, 48'h0, 32'h0000_A5C3, 3'b000, "R3");
    // R4/R9 one bank upset
    m = 48'h0000_0010_0000;
    doRead(12'h003, m, {16'h0, majority(store[3] ^ m)}, 3'b100, "R4");
    // R9 same bit in two banks: vote follows upset
    m = 48'h0001_0001_0000;
    doRead(12'h004, m, {16'h0, majority(store[4] ^ m)}, 3'b100, "R9");
    // R3 scattered upsets, each bit in one bank only
    m = 48'h8000_0300_000C;
    doRead(12'h004, m, 32'h0000_0F0F, 3'b100, "R3");

    // R11 switch mode between accesses
    @(negedge clk);
    modeEdac = 1'b1;
    doWrite(12'h005, 32'h1234_5678, edacWord(32'h1234_5678), "R11");
    doWrite(12'h006, 32'hFFFF_FFFF, edacWord(32'hFFFF_FFFF), "R5");
    doWrite(12'h007, 32'h0000_0000, edacWord(32'h0000_0000), "R5");
    // R6 clean read, spare bits ignored
    doRead(12'h005, 48'h0, 32'h1234_5678, 3'b000, "R6");
    doRead(12'h005, 48'hFF80_0000_0000, 32'h1234_5678, 3'b000, "R6");
    // R7 every single-bit position
    for (int i = 0; i < 39; i++) doRead(12'h005, 48'(1) << i, 32'h1234_5678, 3'b010, "R7");
    doRead(12'h006, 48'(1) << 17, 32'hFFFF_FFFF, 3'b010, "R7");
    doRead(12'h007, 48'(1) << 38, 32'h0000_0000, 3'b010, "R7");
    doRead(12'h007, 48'(1) << 33, 32'h0000_0000, 3'b010, "R7");
    // R8 double errors return raw data
    m = 48'h0000_0000_0021;
    w = store[5] ^ m;
    doRead(12'h005, m, w[31:0], 3'b001, "R8");
    m = 48'h0008_0000_0008;
    w = store[6] ^ m;
    doRead(12'h006, m, w[31:0], 3'b001, "R8");
    m = 48'h0040_0000_0000 | 48'h0000_8000_0000;
    w = store[7] ^ m;
    doRead(12'h007, m, w[31:0], 3'b001, "R8");

    // R11 back to triplicated mode
    @(negedge clk);
    modeEdac = 1'b0;
    doWrite(12'h008, 32'h0000_3C3C, {3{16'h3C3C}}, "R11");
    doRead(12'h008, 48'h0, 32'h0000_3C3C, 3'b000, "R11");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule